// File: doc/BRIEF.md
# GPIO Interrupt Detector

A bank of per-pin interrupt detectors for general-purpose I/O pads. Each pin watches its already-synchronized input. It sets a status bit when its configured condition occurs: a level, a rising edge, a falling edge or both edges. The status bits of enabled pins are ORed into one summary interrupt line. Each pin has its own configuration: an interrupt enable, a raw-recording enable, a detection-mode field, a polarity bit, an acknowledge-polarity bit and a 3-bit routing target.

Edge status bits are sticky until software acknowledges them. Each pin can choose whether writing 1 or writing 0 to its status bit clears it. Level status bits track the active level directly. The detection field is either 2 bits wide, with both-edge capture built in, or 1 bit wide, selecting edge or level. A parameter selects the width. The block does not act on the routing target. It reports the target of the lowest-numbered pending pin.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset, every status bit, the summary interrupt and the reported target are 0.
- R2: With the 2-bit detection field at 0 (level), the status bit equals 1 exactly while the pin equals the polarity bit (1 = active high, 0 = active low), one clock after the pin settles.
- R3: With detection field 1 (rising), a 0-to-1 transition of the pin sets the status bit one clock later. The bit then stays set when the pin falls.
- R4: With detection field 2 (falling), only a 1-to-0 transition sets the status bit. A rising transition leaves it clear.
- R5: With detection field 3 (both edges), a transition in either direction sets the status bit.
- R6: When the raw-recording enable is 1 and the interrupt enable is 0, events still set the status bit, but the summary interrupt stays 0.
- R7: When both the raw-recording enable and the interrupt enable are 0, events leave the status bit at 0.
- R8: An acknowledge write to an edge-mode pin clears its status bit only when the written value equals that pin's acknowledge-polarity bit. A write of the other value has no effect.
- R9: An edge event in the same cycle as a clearing acknowledge leaves the status bit set.
- R10: The summary interrupt is 1 while any pin has both its status bit and its interrupt enable set, and 0 otherwise.
- R11: The reported target is the 3-bit target field of the lowest-numbered pin with status and enable both set. It is 0 when no such pin exists.
- R12: With a 1-bit detection field, the bit set to 1 selects edge detection, with polarity 1 for rising and 0 for falling. The bit set to 0 selects level detection, with the same polarity meaning as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Synchronized pad inputs |
| irq_en_i | input | N_PINS | Per-pin interrupt enable |
| raw_en_i | input | N_PINS | Per-pin raw-recording enable |
| det_mode_i | input | N_PINS*DET_W | Per-pin detection field, pin k at bits [k*DET_W +: DET_W] |
| pol_i | input | N_PINS | Per-pin polarity |
| ack_high_i | input | N_PINS | Per-pin acknowledge polarity: value that clears |
| target_i | input | N_PINS*TGT_W | Per-pin routing target, pin k at [k*TGT_W +: TGT_W] |
| ack_we_i | input | N_PINS | Per-pin acknowledge write strobe |
| ack_val_i | input | N_PINS | Value written by the acknowledge |
| status_o | output | N_PINS | Per-pin status bits |
| irq_o | output | 1 | Summary interrupt |
| irq_target_o | output | TGT_W | Target of the lowest pending pin |

## Verification
A wrong previous-input register or event decode shows on status_o one clock after the offending pin transition. This happens either as a bit that sets on the wrong edge direction or as a bit that fails to set. A corrupted status flop appears at the ports in the same cycle: on status_o, on irq_o when the pin is enabled, and on irq_target_o when it is the lowest pending pin. Acknowledge faults appear one clock after the write, as a bit that fails to clear or clears on the wrong value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;
endpackage

// File: rtl/gpio_irq_event.sv
module gpio_irq_event #(
  parameter int DET_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [DET_W-1:0] mode_i,
  input  logic             pol_i,
  output logic             evt_o,
  output logic             level_o
);
  import gpio_irq_pkg::*;

  logic prev_q, rise, fall, lvl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign rise    = pin_i & ~prev_q;
  assign fall    = ~pin_i & prev_q;
  assign lvl_hit = (pin_i == pol_i);

  generate
    if (DET_W == 2) begin : g_wide
      det_mode_e mode;
      assign mode = det_mode_e'(mode_i);
      always_comb begin
        level_o = 1'b0;
        unique case (mode)
          DET_LEVEL: begin evt_o = lvl_hit; level_o = 1'b1; end
          DET_RISE:  evt_o = rise;
          DET_FALL:  evt_o = fall;
          DET_BOTH:  evt_o = rise | fall;
          default:   evt_o = 1'b0;
        endcase
      end
    end else begin : g_narrow
      // bit set: edge mode, polarity picks direction
      assign level_o = ~mode_i[0];
      assign evt_o   = mode_i[0] ? (pol_i ? rise : fall) : lvl_hit;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic level_i,
  input  logic rec_i,
  input  logic ack_we_i,
  input  logic ack_val_i,
  input  logic ack_high_i,
  output logic status_o
);
  logic status_q, ack_clr;

  assign ack_clr = ack_we_i & (ack_val_i == ack_high_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             status_q <= 1'b0;
    else if (level_i)        status_q <= rec_i & evt_i;
    else if (rec_i && evt_i) status_q <= 1'b1;
    else if (ack_clr)        status_q <= 1'b0;
  end

  assign status_o = status_q;

  assert_no_spurious_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_i && !status_q) |=> !status_q);
  assert_rose_needs_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(rec_i && evt_i));
  assert_event_beats_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && rec_i && evt_i && ack_we_i) |=> status_q);
  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && !evt_i && ack_we_i && (ack_val_i == ack_high_i)) |=> !status_q);
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int N_PINS = 4,
  parameter int TGT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_PINS-1:0]       status_i,
  input  logic [N_PINS-1:0]       en_i,
  input  logic [N_PINS*TGT_W-1:0] target_i,
  output logic                    irq_o,
  output logic [TGT_W-1:0]        target_o
);
  logic [N_PINS-1:0] pend;

  assign pend  = status_i & en_i;
  assign irq_o = |pend;

  always_comb begin
    target_o = '0;
    for (int k = N_PINS - 1; k >= 0; k--)
      if (pend[k]) target_o = target_i[k*TGT_W +: TGT_W];
  end

  assert_idle_target_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (target_o == '0));
  assert_pending_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[0] && en_i[0]) |-> (irq_o && target_o == target_i[TGT_W-1:0]));
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector #(
  parameter int N_PINS = 4,
  parameter int DET_W  = 2,
  parameter int TGT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_PINS-1:0]       pin_i,
  input  logic [N_PINS-1:0]       irq_en_i,
  input  logic [N_PINS-1:0]       raw_en_i,
  input  logic [N_PINS*DET_W-1:0] det_mode_i,
  input  logic [N_PINS-1:0]       pol_i,
  input  logic [N_PINS-1:0]       ack_high_i,
  input  logic [N_PINS*TGT_W-1:0] target_i,
  input  logic [N_PINS-1:0]       ack_we_i,
  input  logic [N_PINS-1:0]       ack_val_i,
  output logic [N_PINS-1:0]       status_o,
  output logic                    irq_o,
  output logic [TGT_W-1:0]        irq_target_o
);
  logic [N_PINS-1:0] evt, level;

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin
    gpio_irq_event #(.DET_W(DET_W)) u_evt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_i[k]),
      .mode_i  (det_mode_i[k*DET_W +: DET_W]),
      .pol_i   (pol_i[k]),
      .evt_o   (evt[k]),
      .level_o (level[k])
    );
    gpio_irq_status u_stat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[k]),
      .level_i    (level[k]),
      .rec_i      (raw_en_i[k] | irq_en_i[k]),
      .ack_we_i   (ack_we_i[k]),
      .ack_val_i  (ack_val_i[k]),
      .ack_high_i (ack_high_i[k]),
      .status_o   (status_o[k])
    );
  end

  gpio_irq_summary #(.N_PINS(N_PINS), .TGT_W(TGT_W)) u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_o),
    .en_i     (irq_en_i),
    .target_i (target_i),
    .irq_o    (irq_o),
    .target_o (irq_target_o)
  );
endmodule

// File: tb/gpio_irq_detector_bench.sv
module gpio_irq_detector_bench;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] pin = '0, en = '0, raw = '0, pol = '0, ackh = '0, we = '0, av = '0;
  logic [2*N-1:0] mode = {N{2'd1}};
  logic [3*N-1:0] tgt = '0;
  logic [N-1:0] st;
  logic irq;
  logic [2:0] itgt;

  logic [1:0] pin1 = '0, en1 = '0, raw1 = '0, pol1 = '0, ackh1 = '0, we1 = '0, av1 = '0, mode1 = '0;
  logic [5:0] tgt1 = '0;
  logic [1:0] st1;
  logic irq1;
  logic [2:0] itgt1;

  gpio_irq_detector #(.N_PINS(N), .DET_W(2), .TGT_W(3)) u_gpio_irq_detector (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .irq_en_i(en), .raw_en_i(raw),
    .det_mode_i(mode), .pol_i(pol), .ack_high_i(ackh), .target_i(tgt),
    .ack_we_i(we), .ack_val_i(av), .status_o(st), .irq_o(irq), .irq_target_o(itgt));

  gpio_irq_detector #(.N_PINS(2), .DET_W(1), .TGT_W(3)) u_gpio_irq_detector_w1 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin1), .irq_en_i(en1), .raw_en_i(raw1),
    .det_mode_i(mode1), .pol_i(pol1), .ack_high_i(ackh1), .target_i(tgt1),
    .ack_we_i(we1), .ack_val_i(av1), .status_o(st1), .irq_o(irq1), .irq_target_o(itgt1));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic step(); @(negedge clk); endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ack(int k, bit v);
    we[k] = 1'b1; av[k] = v; step(); we[k] = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", st, 0); check("R1 irq", irq, 0); check("R1 target", itgt, 0);
    check("R1 status w1", st1, 0);
  endtask

  task automatic t_level();
    mode[1:0] = 2'd0; pol[0] = 1'b1; en[0] = 1'b1; step();
    check("R2 low pin inactive", st[0], 0);
    pin[0] = 1'b1; step();
    check("R2 high active", st[0], 1); check("R10 irq on level", irq, 1);
    pin[0] = 1'b0; step();
    check("R2 follows back low", st[0], 0); check("R10 irq off", irq, 0);
    pol[0] = 1'b0; step();
    check("R2 active low", st[0], 1);
    en[0] = 1'b0; step();
    check("R2 disabled level", st[0], 0);
  endtask

  task automatic t_rise_ack();
    en[1] = 1'b1; ackh[1] = 1'b1;
    pin[1] = 1'b1; step();
    check("R3 rise sets", st[1], 1);
    pin[1] = 1'b0; step();
    check("R3 sticky after fall", st[1], 1);
    ack(1, 1'b0); step();
    check("R8 wrong value ignored", st[1], 1);
    ack(1, 1'b1);
    check("R8 ack-high clears", st[1], 0);
    ackh[1] = 1'b0;
    pin[1] = 1'b1; step();
    check("R3 rise again", st[1], 1);
    ack(1, 1'b1);
    check("R8 write 1 ignored when ack-low", st[1], 1);
    ack(1, 1'b0);
    check("R8 ack-low clears", st[1], 0);
    pin[1] = 1'b0; step();
    check("R3 fall no set", st[1], 0);
    pin[1] = 1'b1; we[1] = 1'b1; av[1] = 1'b0; step(); we[1] = 1'b0;
    check("R9 event wins over ack", st[1], 1);
    ack(1, 1'b0);
    pin[1] = 1'b0; step();
  endtask

  task automatic t_fall_both();
    mode[5:4] = 2'd2; en[2] = 1'b1; ackh[2] = 1'b1;
    pin[2] = 1'b1; step();
    check("R4 rise ignored", st[2], 0);
    pin[2] = 1'b0; step();
    check("R4 fall sets", st[2], 1);
    ack(2, 1'b1);
    mode[5:4] = 2'd3; pin[2] = 1'b1; step();
    check("R5 both rise", st[2], 1);
    ack(2, 1'b1);
    check("R5 cleared", st[2], 0);
    pin[2] = 1'b0; step();
    check("R5 both fall", st[2], 1);
    ack(2, 1'b1); en[2] = 1'b0;
  endtask

  task automatic t_raw();
    raw[3] = 1'b1; en[3] = 1'b0; ackh[3] = 1'b1;
    pin[3] = 1'b1; step();
    check("R6 raw records", st[3], 1); check("R6 irq stays low", irq, 0);
    ack(3, 1'b1); raw[3] = 1'b0; pin[3] = 1'b0; step();
    pin[3] = 1'b1; step();
    check("R7 no record", st[3], 0);
    pin[3] = 1'b0; step();
  endtask

  task automatic t_target();
    tgt = '0; tgt[5:3] = 3'd5; tgt[8:6] = 3'd3;
    en[1] = 1'b1; en[2] = 1'b1; mode[5:4] = 2'd1;
    check("R11 idle target", itgt, 0);
    pin[2] = 1'b1; step();
    check("R11 single pending", itgt, 3);
    pin[1] = 1'b1; step();
    check("R11 lowest wins", itgt, 5); check("R10 irq two pending", irq, 1);
    ack(1, 1'b0);
    check("R11 next pending", itgt, 3);
    ack(2, 1'b1);
    check("R10 irq cleared", irq, 0); check("R11 target back to 0", itgt, 0);
  endtask

  task automatic t_narrow();
    mode1 = 2'b11; pol1 = 2'b10; en1 = 2'b11;
    pin1 = 2'b01; step();
    check("R12 falling pin ignores rise", st1[0], 0);
    pin1 = 2'b00; step();
    check("R12 falling pin sets", st1[0], 1);
    pin1 = 2'b10; step();
    check("R12 rising pin sets", st1[1], 1);
    mode1 = 2'b00; we1 = 2'b11; av1 = 2'b00; step(); we1 = 2'b00;
    check("R12 level active high", st1[1], 1);
    check("R12 level active low", st1[0], 1);
    pin1 = 2'b01; step();
    check("R12 level follows", st1, 2'b00);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_level();
    t_rise_ack();
    t_fall_both();
    t_raw();
    t_target();
    t_narrow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule